// File: doc/BRIEF.md
# I2C Sectioned Register and Memory Access Front End

This block is the bus-side half of a timekeeping device. It decodes I2C transactions coming from an external master and turns them into byte reads and write strobes. Two separate spaces sit behind it. The register space holds 48 bytes (00h..2Fh) and is divided into fixed sections. The memory space is a 128-byte general store. Each space answers on its own 7-bit slave address, and a single transaction can reach only one of them. The block holds a separate byte pointer for each space. A transfer may start at any byte. Auto-increment walks forward but always stays inside the section where the transfer started.

The register owners keep the actual contents. This block presents a read address and takes back the byte at that address. It emits one-cycle write strobes with an address and a data byte. For the clock section it gates those strobes with an enable bit that the owner supplies. When a register-space read begins, all clock and alarm bytes are copied into a local buffer. Any byte of those sections read later in the same transaction is served from that buffer, so every byte returned comes from the same moment in time. SCL and SDA are oversampled by the system clock, which must run at least 16 times the SCL rate. SDA is driven only as an active-low output enable.

Top module: `i2c_sect_regif`

## Requirements
- R1: The slave acknowledges address byte 1101111 (register space) and 1010111 (memory space). It NACKs any other slave address and ignores every later byte until the next START or STOP.
- R2: In register space, a word address above 2Fh is NACKed. In memory space, a word address with bit 7 set is NACKed. Neither case produces a write strobe.
- R3: Register sections are [00-06], [07-0F], [10-15], [16-1A], [1B-1F], [20-27], [28-29], [2A-2B], [2C], [2D] and [2E-2F]. After each data byte of a page write, the pointer moves to the next byte, or back to the first byte of the same section once the section's last byte has been written.
- R4: A sequential read follows the same wrap rule and never leaves its section.
- R5: A write to the clock section (00h..06h) produces a strobe only while `rtc_wr_en_i` is high. Without the enable, the byte is still ACKed, the pointer still advances, and the stored value stays unchanged.
- R6: At the slave-address byte of a register-space read, all clock bytes (`time_i`) and alarm bytes (`alarm_i`) are captured. Byte k of each vector occupies bits [8k+7:8k], and the alarm bytes map to 10h..15h. Reads of those sections return the captured value, even if the inputs change during the read.
- R7: After a read, the pointer holds the last address read plus one (with section wrap). A read that starts with no word address continues from that point.
- R8: A repeated START returns the byte state machine to the slave-address phase but keeps the pointer, so writing a word address and then issuing a repeated-START read works.
- R9: Memory writes raise `mem_we_o` with a 7-bit address. Memory reads return `mem_rdata_i`. The memory pointer is separate from the register pointer and wraps from 7Fh to 00h. `reg_we_o` and `mem_we_o` are never high together.
- R10: After reset, `sda_oe_o`, `reg_we_o` and `mem_we_o` are low.
- R11: When the master NACKs a read byte, the slave releases SDA and sends nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low |
| reg_raddr_o | output | 6 | Register-space pointer, read address to owners |
| reg_rdata_i | input | 8 | Byte at `reg_raddr_o` from owners |
| time_i | input | 56 | Live clock bytes 00h..06h |
| alarm_i | input | 48 | Live alarm bytes 10h..15h |
| rtc_wr_en_i | input | 1 | Clock-section write enable |
| reg_we_o | output | 1 | Register write strobe |
| mem_raddr_o | output | 7 | Memory-space pointer, read address |
| mem_rdata_i | input | 8 | Byte at `mem_raddr_o` |
| mem_we_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 7 | Write address for either strobe |
| wr_data_o | output | 8 | Write data for either strobe |

## Verification
The bench builds the block with its default parameters: slave addresses 6Fh and 57h, a 7-byte clock, a 6-byte alarm block at 10h, a 7-bit memory pointer and a two-stage synchronizer. With these values a short run reaches the 7Fh-to-00h memory wrap, the single-byte sections where every page-write byte lands on the same address, and the clock section's wrap from 06h to 00h. The bench's owner model connects the clock enable to bit 6 of register 08h. That lets the gate be opened through the bus itself, and a write made without the enable can be shown to have no effect by reading it back.

// File: rtl/i2c_sect_pkg.sv
package i2c_sect_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADR, ST_WDAT, ST_RDAT, ST_SKIP
  } bus_st_e;

  function automatic logic [5:0] sect_base(input logic [5:0] a);
    if (a <= 6'h06)      return 6'h00;
    else if (a <= 6'h0F) return 6'h07;
    else if (a <= 6'h15) return 6'h10;
    else if (a <= 6'h1A) return 6'h16;
    else if (a <= 6'h1F) return 6'h1B;
    else if (a <= 6'h27) return 6'h20;
    else if (a <= 6'h29) return 6'h28;
    else if (a <= 6'h2B) return 6'h2A;
    else if (a == 6'h2C) return 6'h2C;
    else if (a == 6'h2D) return 6'h2D;
    else                 return 6'h2E;
  endfunction

  function automatic logic [5:0] sect_last(input logic [5:0] a);
    if (a <= 6'h06)      return 6'h06;
    else if (a <= 6'h0F) return 6'h0F;
    else if (a <= 6'h15) return 6'h15;
    else if (a <= 6'h1A) return 6'h1A;
    else if (a <= 6'h1F) return 6'h1F;
    else if (a <= 6'h27) return 6'h27;
    else if (a <= 6'h29) return 6'h29;
    else if (a <= 6'h2B) return 6'h2B;
    else if (a == 6'h2C) return 6'h2C;
    else if (a == 6'h2D) return 6'h2D;
    else                 return 6'h2F;
  endfunction

  function automatic logic [5:0] sect_next(input logic [5:0] a);
    return (a == sect_last(a)) ? sect_base(a) : a + 6'd1;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_ff[STAGES-1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[STAGES-1] & scl_q;
  // SDA edges with SCL held high mark bus conditions
  assign start_o = scl_ff[STAGES-1] & scl_q & sda_q & ~sda_ff[STAGES-1];
  assign stop_o  = scl_ff[STAGES-1] & scl_q & ~sda_q & sda_ff[STAGES-1];
endmodule

// File: rtl/i2c_snap_buf.sv
module i2c_snap_buf #(
  parameter int          AW       = 6,
  parameter int          CLK_N    = 7,
  parameter int          ALM_N    = 6,
  parameter logic [5:0]  ALM_BASE = 6'h10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [CLK_N*8-1:0] time_i,
  input  logic [ALM_N*8-1:0] alarm_i,
  input  logic [AW-1:0]      addr_i,
  output logic               hit_o,
  output logic [7:0]         data_o
);
  logic [7:0] clk_q [CLK_N];
  logic [7:0] alm_q [ALM_N];

  for (genvar g = 0; g < CLK_N; g++) begin : g_clk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    clk_q[g] <= '0;
      else if (cap_i) clk_q[g] <= time_i[g*8 +: 8];
    end
  end

  for (genvar g = 0; g < ALM_N; g++) begin : g_alm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    alm_q[g] <= '0;
      else if (cap_i) alm_q[g] <= alarm_i[g*8 +: 8];
    end
  end

  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int k = 0; k < CLK_N; k++) begin
      if (addr_i == AW'(k)) begin
        hit_o  = 1'b1;
        data_o = clk_q[k];
      end
    end
    for (int k = 0; k < ALM_N; k++) begin
      if (addr_i == AW'(ALM_BASE) + AW'(k)) begin
        hit_o  = 1'b1;
        data_o = alm_q[k];
      end
    end
  end
endmodule

// File: rtl/i2c_sect_regif.sv
module i2c_sect_regif
  import i2c_sect_pkg::*;
#(
  parameter logic [6:0] REG_DEV  = 7'h6F,
  parameter logic [6:0] MEM_DEV  = 7'h57,
  parameter logic [7:0] REG_LAST = 8'h2F,
  parameter int         CLK_N    = 7,
  parameter int         ALM_N    = 6,
  parameter logic [5:0] ALM_BASE = 6'h10,
  parameter int         MEM_AW   = 7,
  parameter int         SYNC_N   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [5:0]         reg_raddr_o,
  input  logic [7:0]         reg_rdata_i,
  input  logic [CLK_N*8-1:0] time_i,
  input  logic [ALM_N*8-1:0] alarm_i,
  input  logic               rtc_wr_en_i,
  output logic               reg_we_o,
  output logic [MEM_AW-1:0]  mem_raddr_o,
  input  logic [7:0]         mem_rdata_i,
  output logic               mem_we_o,
  output logic [MEM_AW-1:0]  wr_addr_o,
  output logic [7:0]         wr_data_o
);
  localparam int         REG_AW   = 6;
  localparam logic [5:0] CLK_LAST = 6'(CLK_N - 1);

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  bus_st_e st;
  logic [3:0] bitcnt;
  logic ack_ph, mack, mem_sel, oe_q, cap_q, reg_we_q, mem_we_q;
  logic [7:0] shreg, wr_data_q;
  logic [6:0] txq;
  logic [REG_AW-1:0] reg_ptr;
  logic [MEM_AW-1:0] mem_ptr, wr_addr_q;
  logic snap_hit;
  logic [7:0] snap_data, rd_byte;
  logic dev_reg, dev_mem, wadr_ok;

  i2c_line_sync #(.STAGES(SYNC_N)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  i2c_snap_buf #(.AW(REG_AW), .CLK_N(CLK_N), .ALM_N(ALM_N), .ALM_BASE(ALM_BASE)) i_snap (
    .clk_i, .rst_ni, .cap_i(cap_q), .time_i, .alarm_i,
    .addr_i(reg_ptr), .hit_o(snap_hit), .data_o(snap_data)
  );

  assign dev_reg = (shreg[7:1] == REG_DEV);
  assign dev_mem = (shreg[7:1] == MEM_DEV);
  assign wadr_ok = mem_sel ? (shreg[7:MEM_AW] == '0) : (shreg <= REG_LAST);
  assign rd_byte = mem_sel ? mem_rdata_i : (snap_hit ? snap_data : reg_rdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; bitcnt <= '0; ack_ph <= 1'b0; mack <= 1'b0;
      mem_sel <= 1'b0; oe_q <= 1'b0; cap_q <= 1'b0;
      reg_we_q <= 1'b0; mem_we_q <= 1'b0;
      shreg <= '0; txq <= '0; wr_data_q <= '0; wr_addr_q <= '0;
      reg_ptr <= '0; mem_ptr <= '0;
    end else begin
      reg_we_q <= 1'b0;
      mem_we_q <= 1'b0;
      cap_q    <= 1'b0;
      if (bus_start) begin
        st <= ST_DEV; bitcnt <= '0; ack_ph <= 1'b0; oe_q <= 1'b0;
      end else if (bus_stop) begin
        st <= ST_IDLE; bitcnt <= '0; ack_ph <= 1'b0; oe_q <= 1'b0;
      end else if (st != ST_IDLE && st != ST_SKIP) begin
        if (scl_rise) begin
          if (ack_ph) mack <= ~sda_s;  // own ACK after address reads as master ACK
          else begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (ack_ph) begin
            ack_ph <= 1'b0;
            oe_q   <= 1'b0;
            if (st == ST_RDAT) begin
              if (mack) begin
                txq  <= rd_byte[6:0];
                oe_q <= ~rd_byte[7];
              end else st <= ST_SKIP;
            end
          end else if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            ack_ph <= 1'b1;
            unique case (st)
              ST_DEV: begin
                if (dev_reg || dev_mem) begin
                  oe_q    <= 1'b1;
                  mem_sel <= dev_mem;
                  st      <= shreg[0] ? ST_RDAT : ST_WADR;
                  cap_q   <= shreg[0] & dev_reg;
                end else st <= ST_SKIP;
              end
              ST_WADR: begin
                if (wadr_ok) begin
                  oe_q <= 1'b1;
                  st   <= ST_WDAT;
                  if (mem_sel) mem_ptr <= shreg[MEM_AW-1:0];
                  else         reg_ptr <= shreg[REG_AW-1:0];
                end else st <= ST_SKIP;
              end
              ST_WDAT: begin
                oe_q      <= 1'b1;
                wr_data_q <= shreg;
                if (mem_sel) begin
                  mem_we_q  <= 1'b1;
                  wr_addr_q <= mem_ptr;
                  mem_ptr   <= mem_ptr + 1'b1;
                end else begin
                  reg_we_q  <= (reg_ptr > CLK_LAST) | rtc_wr_en_i;
                  wr_addr_q <= MEM_AW'(reg_ptr);
                  reg_ptr   <= sect_next(reg_ptr);
                end
              end
              ST_RDAT: begin
                oe_q <= 1'b0;
                if (mem_sel) mem_ptr <= mem_ptr + 1'b1;
                else         reg_ptr <= sect_next(reg_ptr);
              end
              default: st <= ST_SKIP;
            endcase
          end else if (st == ST_RDAT) begin
            oe_q <= ~txq[6];
            txq  <= {txq[5:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_raddr_o = reg_ptr;
  assign mem_raddr_o = mem_ptr;
  assign reg_we_o    = reg_we_q;
  assign mem_we_o    = mem_we_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;

  a_r5_clk_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && wr_addr_o[REG_AW-1:0] <= CLK_LAST) |-> $past(rtc_wr_en_i));
  a_r3_stay_in_sect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> sect_base(reg_ptr) == sect_base(wr_addr_o[REG_AW-1:0]));
  a_r2_reg_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ({1'b0, wr_addr_o} <= REG_LAST));
  a_r9_one_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, mem_we_o}));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe_o);
  a_r11_skip_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SKIP) |-> !sda_oe_o);
endmodule

// File: tb/test_i2c_sect_regif.sv
module test_i2c_sect_regif;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, bus_sda;
  logic [5:0] reg_raddr;
  logic [6:0] mem_raddr, wr_addr;
  logic [7:0] reg_rdata, mem_rdata, wr_data;
  logic [55:0] time_v;
  logic [47:0] alarm_v;
  logic reg_we, mem_we, rtc_en;

  logic [7:0] reg_mem [48];
  logic [7:0] mem_arr [128];
  logic poke_en = 1'b0;
  logic [5:0] poke_a = '0;
  logic [7:0] poke_d = '0;

  int n_chk = 0, n_fail = 0;
  int exp_wr[$];
  string wr_tag = "R3";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus_sda = m_sda & ~sda_oe;

  i2c_sect_regif i_i2c_sect_regif (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe_o(sda_oe),
    .reg_raddr_o(reg_raddr), .reg_rdata_i(reg_rdata), .time_i(time_v), .alarm_i(alarm_v),
    .rtc_wr_en_i(rtc_en), .reg_we_o(reg_we), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  // register and memory owners
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 48; k++) reg_mem[k] <= 8'h00;
      for (int k = 0; k < 128; k++) mem_arr[k] <= 8'h00;
    end else begin
      if (reg_we) reg_mem[wr_addr[5:0]] <= wr_data;
      if (mem_we) mem_arr[wr_addr] <= wr_data;
      if (poke_en) reg_mem[poke_a] <= poke_d;
    end
  end
  always_comb begin
    for (int k = 0; k < 7; k++) time_v[k*8 +: 8] = reg_mem[k];
    for (int k = 0; k < 6; k++) alarm_v[k*8 +: 8] = reg_mem[16+k];
  end
  assign rtc_en    = reg_mem[8][6];
  assign reg_rdata = reg_mem[reg_raddr];
  assign mem_rdata = mem_arr[mem_raddr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference of write strobes, compared every clock
  always @(negedge clk) begin
    if (rst_n && (reg_we || mem_we)) begin
      int got;
      got = (int'(mem_we) << 16) | (int'(wr_addr) << 8) | int'(wr_data);
      if (reg_we && mem_we) chk(1'b0, "R9 both strobes", 3, 1);
      else if (exp_wr.size() == 0) chk(1'b0, wr_tag, got, 0);
      else begin
        int e;
        e = exp_wr.pop_front();
        chk(got == e, wr_tag, got, e);
      end
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start(); m_sda = 1; m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q); endtask
  task automatic bus_rstart(); m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q); endtask
  task automatic bus_stop(); m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(2*Q); endtask
  task automatic bit_out(input logic b); m_sda = b; tick(Q); m_scl = 1; tick(2*Q); m_scl = 0; tick(Q); endtask
  task automatic bit_in(output logic b); m_sda = 1; tick(Q); m_scl = 1; tick(Q); b = bus_sda; tick(Q); m_scl = 0; tick(Q); endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    chk(!x == exp_ack, tag, int'(!x), int'(exp_ack));
  endtask

  task automatic recv(input bit ack, input logic [7:0] exp, input string tag);
    logic [7:0] b;
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); b[i] = x; end
    bit_out(!ack);
    chk(b == exp, tag, int'(b), int'(exp));
  endtask

  function automatic int wexp(input bit m, input int a, input int d);
    return (int'(m) << 16) | (a << 8) | d;
  endfunction

  initial begin
    tick(5); rst_n = 1; tick(5);
    chk(sda_oe == 0, "R10 sda_oe after reset", int'(sda_oe), 0);
    chk(reg_we == 0 && mem_we == 0, "R10 strobes after reset", int'({reg_we, mem_we}), 0);

    // R5: clock write without enable is ignored
    wr_tag = "R5 gated clock write";
    bus_start(); send(8'hDE, 1, "R1 register slave address"); send(8'h00, 1, "R5 word addr");
    send(8'h11, 1, "R5 gated byte still acked"); bus_stop();
    bus_start(); send(8'hDE, 1, "R5"); send(8'h00, 1, "R5"); bus_rstart();
    send(8'hDF, 1, "R8 read after repeated start"); recv(0, 8'h00, "R5 clock byte unchanged"); bus_stop();

    // enable clock writes
    wr_tag = "R5 enable write";
    exp_wr.push_back(wexp(0, 8, 8'h40));
    bus_start(); send(8'hDE, 1, "R5"); send(8'h08, 1, "R5"); send(8'h40, 1, "R5"); bus_stop();

    // R3: page write wraps inside clock section
    wr_tag = "R3 clock page write";
    exp_wr.push_back(wexp(0, 4, 8'hA4)); exp_wr.push_back(wexp(0, 5, 8'hA5));
    exp_wr.push_back(wexp(0, 6, 8'hA6)); exp_wr.push_back(wexp(0, 0, 8'hA0));
    exp_wr.push_back(wexp(0, 1, 8'hA1));
    bus_start(); send(8'hDE, 1, "R3"); send(8'h04, 1, "R3");
    send(8'hA4, 1, "R3"); send(8'hA5, 1, "R3"); send(8'hA6, 1, "R3");
    send(8'hA0, 1, "R3"); send(8'hA1, 1, "R3"); bus_stop();

    // R4 sequential read wrap, R8 repeated start, R11 release
    bus_start(); send(8'hDE, 1, "R8"); send(8'h05, 1, "R8"); bus_rstart(); send(8'hDF, 1, "R8");
    recv(1, 8'hA5, "R8 first byte at written pointer"); recv(1, 8'hA6, "R4 second byte");
    recv(0, 8'hA0, "R4 wrap to section start");
    tick(3); chk(sda_oe == 0, "R11 released after master NACK", int'(sda_oe), 0);
    bus_stop();

    // R7 current-address read
    bus_start(); send(8'hDF, 1, "R7"); recv(0, 8'hA1, "R7 current address read"); bus_stop();

    // R6 snapshot
    bus_start(); send(8'hDE, 1, "R6"); send(8'h00, 1, "R6"); bus_rstart(); send(8'hDF, 1, "R6");
    poke_a = 6'd1; poke_d = 8'h77; poke_en = 1; tick(1); poke_en = 0;
    recv(1, 8'hA0, "R6 byte 0"); recv(0, 8'hA1, "R6 byte 1 from snapshot"); bus_stop();
    bus_start(); send(8'hDE, 1, "R6"); send(8'h01, 1, "R6"); bus_rstart(); send(8'hDF, 1, "R6");
    recv(0, 8'h77, "R6 new capture on next read"); bus_stop();

    // R3 alarm section wrap and single-byte section
    wr_tag = "R3 alarm page write";
    exp_wr.push_back(wexp(0, 8'h14, 8'hB4)); exp_wr.push_back(wexp(0, 8'h15, 8'hB5));
    exp_wr.push_back(wexp(0, 8'h10, 8'hB0));
    bus_start(); send(8'hDE, 1, "R3"); send(8'h14, 1, "R3");
    send(8'hB4, 1, "R3"); send(8'hB5, 1, "R3"); send(8'hB0, 1, "R3"); bus_stop();
    wr_tag = "R3 single-byte section";
    exp_wr.push_back(wexp(0, 8'h2C, 8'hD0)); exp_wr.push_back(wexp(0, 8'h2C, 8'hD1));
    bus_start(); send(8'hDE, 1, "R3"); send(8'h2C, 1, "R3");
    send(8'hD0, 1, "R3"); send(8'hD1, 1, "R3"); bus_stop();
    bus_start(); send(8'hDE, 1, "R4"); send(8'h2C, 1, "R4"); bus_rstart(); send(8'hDF, 1, "R4");
    recv(1, 8'hD1, "R4 single-byte section"); recv(0, 8'hD1, "R4 single-byte wrap"); bus_stop();

    // R2 / R1 rejections
    wr_tag = "R2 no strobe on bad address";
    bus_start(); send(8'hDE, 1, "R2"); send(8'h30, 0, "R2 register word addr above 2Fh NACK");
    send(8'h55, 0, "R2 following byte ignored"); bus_stop();
    wr_tag = "R1 no strobe for foreign slave";
    bus_start(); send(8'hA0, 0, "R1 foreign slave address NACK");
    send(8'h00, 0, "R1 later byte ignored"); bus_stop();

    // R9 memory space
    wr_tag = "R9 memory page write";
    exp_wr.push_back(wexp(1, 8'h7E, 8'hC0)); exp_wr.push_back(wexp(1, 8'h7F, 8'hC1));
    exp_wr.push_back(wexp(1, 8'h00, 8'hC2));
    bus_start(); send(8'hAE, 1, "R1 memory slave address"); send(8'h7E, 1, "R9");
    send(8'hC0, 1, "R9"); send(8'hC1, 1, "R9"); send(8'hC2, 1, "R9"); bus_stop();
    bus_start(); send(8'hAE, 1, "R9"); send(8'h7F, 1, "R9"); bus_rstart(); send(8'hAF, 1, "R9");
    recv(1, 8'hC1, "R9 memory read"); recv(0, 8'hC2, "R9 memory wrap 7Fh to 00h"); bus_stop();
    wr_tag = "R2 memory bad address";
    bus_start(); send(8'hAE, 1, "R2"); send(8'h80, 0, "R2 memory word addr bit7 NACK"); bus_stop();
    // register pointer untouched by memory traffic (ptr was 2Ch after last register read)
    bus_start(); send(8'hDF, 1, "R9"); recv(0, 8'hD1, "R9 separate register pointer"); bus_stop();

    tick(20);
    chk(exp_wr.size() == 0, "R3 all expected strobes seen", exp_wr.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1 watchdog timeout", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule